// File: doc/BRIEF.md
# Fixed-Point Multiply/Accumulate Datapath

This block is the arithmetic core of a 16-bit fixed-point signal processor. A 16-bit data word comes in on one bus. It can be widened to 32 bits by a scaling shifter, loaded into a temporary operand register, or multiplied against that register. The product lands in a 32-bit product register. A 32-bit accumulator with a carry flag takes its second operand either from the scaled data word or from the product after a four-setting product shifter.

Every state change happens on one clock edge under a 4-bit operation code. The accumulator can be read out as a high or a low 16-bit half through a 0 to 7 bit left shifter. This read path is purely combinational, so it never disturbs the accumulator. Instruction decode, memories and addressing sit outside the block and drive its control inputs directly.

Top module: `mac_datapath`

## Requirements
- R1: While `rst_n` is low at a rising edge, the accumulator, product register, temporary register and carry all become zero.
- R2: The scaled word is the data word shifted left by `scale_i` bits, where any amount above 16 acts as 16. Vacated low bits are zero. The upper bits are copies of data bit 15 when `sxm_i`=1 and zero when `sxm_i`=0.
- R3: Op code 7 (load temporary) copies `data_i` into the temporary register. Op code 8 (multiply) captures temporary × `data_i` in the product register at the same edge. The product is two's complement when `signed_mul_i`=1 and unsigned otherwise. Neither op alters the accumulator or carry.
- R4: The product shifter `pshift_i` settings are 0 = pass-through, 1 = left by 1, 2 = left by 4, and 3 = arithmetic right by 6. Vacated low bits are zero.
- R5: The ALU operand is the shifted product when `src_sel_i`=1 and the scaled word when `src_sel_i`=0. Op code 1 (load accumulator) writes that operand into the accumulator and leaves carry unchanged.
- R6: Op code 2 (add) and op code 3 (subtract) update the accumulator modulo 2^32. On add, carry is the carry out of bit 31. On subtract, carry is 1 exactly when no borrow occurs, i.e. when the accumulator is at least the operand as unsigned values.
- R7: Op codes 4, 5 and 6 (AND, OR, XOR) combine the low 16 accumulator bits with the low 16 operand bits. The result goes to accumulator bits 15..0, bits 31..16 become zero, and carry is unchanged.
- R8: Op code 9 (multiply-accumulate) adds the shifted value of the product already held to the accumulator, with carry as on add, regardless of `src_sel_i`. At the same edge it captures a new product of temporary × `data_i`.
- R9: With `store_high_i`=1, `store_o` is bits 31..16 of the accumulator shifted left by `store_shift_i`, so that low-half bits fill in. With `store_high_i`=0, it is the low 16 accumulator bits shifted left with zero fill. Reading `store_o` never changes any register.
- R10: Op code 0 and op codes 10 to 15 leave every register and the carry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 4 | Operation code |
| src_sel_i | input | 1 | ALU operand select: 1 = shifted product, 0 = scaled word |
| data_i | input | 16 | Data bus word |
| scale_i | input | 5 | Scaling shifter amount |
| sxm_i | input | 1 | Sign-extension mode for the scaling shifter |
| signed_mul_i | input | 1 | Signed multiply when 1 |
| pshift_i | input | 2 | Product shifter setting |
| store_high_i | input | 1 | Store path half select: 1 = high, 0 = low |
| store_shift_i | input | 3 | Store path left shift |
| store_o | output | 16 | Shifted accumulator half |
| acc_o | output | 32 | Accumulator |
| prod_o | output | 32 | Product register |
| tmp_o | output | 16 | Temporary operand register |
| carry_o | output | 1 | Carry flag |

## Verification
The assertions assume that every control input is a known value at each rising edge. Op codes 10 to 15 may appear and are treated as no-operations. The stimulus drives every input at the falling edge from defined values only. Random op codes span the whole 4-bit range, so the assertions on the no-operation codes are exercised. Random data, scale amounts from 0 to 31, all product settings and both sign modes are mixed with directed sweeps of every scale amount, product setting and store shift.

// File: rtl/mac_pkg.sv
// Package mac_pkg
// Shared operation codes and product shifter settings for the MAC datapath.
// Assumes a 4-bit operation field and a 2-bit product shift field.
package mac_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_LDACC = 4'd1,
        OP_ADD   = 4'd2,
        OP_SUB   = 4'd3,
        OP_AND   = 4'd4,
        OP_OR    = 4'd5,
        OP_XOR   = 4'd6,
        OP_LDTMP = 4'd7,
        OP_MPY   = 4'd8,
        OP_MAC   = 4'd9
    } mac_op_e;

    typedef enum logic [1:0] {
        PSH_NONE = 2'd0,
        PSH_L1   = 2'd1,
        PSH_L4   = 2'd2,
        PSH_R6   = 2'd3
    } psh_e;

    localparam int unsigned PSH_LEFT_SMALL = 1;
    localparam int unsigned PSH_LEFT_BIG   = 4;
    localparam int unsigned PSH_RIGHT      = 6;

endpackage

// File: rtl/mac_scaler.sv
// Module mac_scaler
// Widens a DW-bit data word to 2*DW bits and shifts it left by 0..DW.
// Amounts above DW saturate at DW. Upper fill is sign or zero per sxm_i.
// Assumes amt_i is wide enough to hold DW.
module mac_scaler #(
    parameter int DW = 16,
    parameter int SW = 5
) (
    input  logic [DW-1:0]   data_i,
    input  logic [SW-1:0]   amt_i,
    input  logic            sxm_i,
    output logic [2*DW-1:0] scaled_o
);
    localparam int WW = 2 * DW;

    logic [SW-1:0] amt_eff;
    logic [WW-1:0] wide;

    // Saturate the amount, extend the word, then shift it.
    always_comb begin
        amt_eff  = (amt_i > SW'(DW)) ? SW'(DW) : amt_i;
        wide     = sxm_i ? {{DW{data_i[DW-1]}}, data_i} : {{DW{1'b0}}, data_i};
        scaled_o = wide << amt_eff;
    end
endmodule

// File: rtl/mac_pshift.sv
// Module mac_pshift
// Product path shifter with four fixed settings: pass, left 1, left 4,
// arithmetic right 6. Purely combinational.
module mac_pshift
    import mac_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] prod_i,
    input  logic [1:0]    mode_i,
    output logic [AW-1:0] shifted_o
);
    // Select one of the four fixed shifts.
    always_comb begin
        unique case (psh_e'(mode_i))
            PSH_L1:  shifted_o = prod_i << PSH_LEFT_SMALL;
            PSH_L4:  shifted_o = prod_i << PSH_LEFT_BIG;
            PSH_R6:  shifted_o = {{PSH_RIGHT{prod_i[AW-1]}}, prod_i[AW-1:PSH_RIGHT]};
            default: shifted_o = prod_i;
        endcase
    end
endmodule

// File: rtl/mac_multiplier.sv
// Module mac_multiplier
// Temporary operand register plus a single-cycle DW x DW multiplier whose
// full-width result is captured in the product register.
// Assumes load and capture strobes are known at every edge.
module mac_multiplier #(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_tmp_i,
    input  logic            cap_i,
    input  logic            signed_i,
    input  logic [DW-1:0]   data_i,
    output logic [DW-1:0]   tmp_o,
    output logic [2*DW-1:0] prod_o
);
    localparam int PW = 2 * DW;

    logic [PW-1:0] a_ext;
    logic [PW-1:0] b_ext;
    logic [PW-1:0] mul;

    // Extend both operands per the sign mode and form the product.
    always_comb begin
        a_ext = signed_i ? {{DW{tmp_o[DW-1]}}, tmp_o}   : {{DW{1'b0}}, tmp_o};
        b_ext = signed_i ? {{DW{data_i[DW-1]}}, data_i} : {{DW{1'b0}}, data_i};
        mul   = a_ext * b_ext;
    end

    // Register the temporary operand and the product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmp_o  <= '0;
            prod_o <= '0;
        end else begin
            if (load_tmp_i) tmp_o  <= data_i;
            if (cap_i)      prod_o <= mul;
        end
    end

    AST_TMP_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) !load_tmp_i |=> $stable(tmp_o)); // R3
    AST_PROD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !cap_i |=> $stable(prod_o)); // R10
    AST_ZERO_PROD: assert property (@(posedge clk) disable iff (!rst_n) (cap_i && data_i == '0) |=> prod_o == '0); // R3
endmodule

// File: rtl/mac_accum.sv
// Module mac_accum
// ALU and accumulator with carry. One input is always the accumulator;
// the other is the operand chosen by the top. Logical ops use the low half.
// Assumes op_i is a known 4-bit value; unlisted codes hold state.
module mac_accum
    import mac_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mac_op_e       op_i,
    input  logic [AW-1:0] operand_i,
    output logic [AW-1:0] acc_o,
    output logic          carry_o
);
    localparam int HW = AW / 2;

    logic [AW:0]   sum;
    logic [AW:0]   dif;
    logic [HW-1:0] lo_res;

    // Extended add and subtract, and the low-half logical result.
    always_comb begin
        sum = {1'b0, acc_o} + {1'b0, operand_i};
        dif = {1'b0, acc_o} - {1'b0, operand_i};
        unique case (op_i)
            OP_AND:  lo_res = acc_o[HW-1:0] & operand_i[HW-1:0];
            OP_OR:   lo_res = acc_o[HW-1:0] | operand_i[HW-1:0];
            default: lo_res = acc_o[HW-1:0] ^ operand_i[HW-1:0];
        endcase
    end

    // Update accumulator and carry per the operation code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o   <= '0;
            carry_o <= 1'b0;
        end else begin
            case (op_i)
                OP_LDACC: acc_o <= operand_i;
                OP_ADD, OP_MAC: begin
                    acc_o   <= sum[AW-1:0];
                    carry_o <= sum[AW];
                end
                OP_SUB: begin
                    acc_o   <= dif[AW-1:0];
                    carry_o <= ~dif[AW];
                end
                OP_AND, OP_OR, OP_XOR: acc_o <= {{HW{1'b0}}, lo_res};
                default: ;
            endcase
        end
    end

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_i inside {OP_LDACC, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_MAC}) |=> $stable(acc_o)); // R10
    AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_i inside {OP_ADD, OP_SUB, OP_MAC}) |=> $stable(carry_o)); // R7
    AST_LOGIC_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i inside {OP_AND, OP_OR, OP_XOR}) |=> acc_o[AW-1:HW] == '0); // R7
    AST_SUB_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SUB && operand_i == acc_o) |=> (acc_o == '0 && carry_o)); // R6
    AST_ADD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ADD && operand_i == '0) |=> ($stable(acc_o) && !carry_o)); // R6
endmodule

// File: rtl/mac_store.sv
// Module mac_store
// Combinational read path: one accumulator half, shifted left 0..7.
// The high half takes fill bits from the top of the low half.
module mac_store #(
    parameter int AW  = 32,
    parameter int SSW = 3
) (
    input  logic [AW-1:0]   acc_i,
    input  logic            high_i,
    input  logic [SSW-1:0]  shift_i,
    output logic [AW/2-1:0] store_o
);
    localparam int HW = AW / 2;

    logic [AW-1:0] full_sh;
    logic [HW-1:0] low_sh;

    // Shift the whole word for the high half, the low half alone otherwise.
    always_comb begin
        full_sh = acc_i << shift_i;
        low_sh  = acc_i[HW-1:0] << shift_i;
        store_o = high_i ? full_sh[AW-1:HW] : low_sh;
    end
endmodule

// File: rtl/mac_datapath.sv
// Module mac_datapath
// Top of the fixed-point MAC datapath: scaler, multiplier, product shifter,
// accumulator and store shifter. Control inputs come straight from decode.
// Assumes all control inputs are known at every rising edge.
module mac_datapath
    import mac_pkg::*;
#(
    parameter int DW  = 16,
    parameter int SW  = 5,
    parameter int SSW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op_i,
    input  logic          src_sel_i,
    input  logic [DW-1:0] data_i,
    input  logic [SW-1:0] scale_i,
    input  logic          sxm_i,
    input  logic          signed_mul_i,
    input  logic [1:0]    pshift_i,
    input  logic          store_high_i,
    input  logic [SSW-1:0] store_shift_i,
    output logic [DW-1:0] store_o,
    output logic [2*DW-1:0] acc_o,
    output logic [2*DW-1:0] prod_o,
    output logic [DW-1:0] tmp_o,
    output logic          carry_o
);
    localparam int AW = 2 * DW;

    mac_op_e       op;
    logic [AW-1:0] scaled;
    logic [AW-1:0] prod_sh;
    logic [AW-1:0] operand;

    // Decode the op code and pick the ALU operand.
    always_comb begin
        op      = mac_op_e'(op_i);
        operand = (src_sel_i || op == OP_MAC) ? prod_sh : scaled;
    end

    mac_scaler #(.DW(DW), .SW(SW)) u_scaler (
        .data_i   (data_i),
        .amt_i    (scale_i),
        .sxm_i    (sxm_i),
        .scaled_o (scaled)
    );

    mac_multiplier #(.DW(DW)) u_mul (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_tmp_i (op == OP_LDTMP),
        .cap_i      (op == OP_MPY || op == OP_MAC),
        .signed_i   (signed_mul_i),
        .data_i     (data_i),
        .tmp_o      (tmp_o),
        .prod_o     (prod_o)
    );

    mac_pshift #(.AW(AW)) u_psh (
        .prod_i    (prod_o),
        .mode_i    (pshift_i),
        .shifted_o (prod_sh)
    );

    mac_accum #(.AW(AW)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op),
        .operand_i (operand),
        .acc_o     (acc_o),
        .carry_o   (carry_o)
    );

    mac_store #(.AW(AW), .SSW(SSW)) u_store (
        .acc_i   (acc_o),
        .high_i  (store_high_i),
        .shift_i (store_shift_i),
        .store_o (store_o)
    );

    AST_MPY_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_MPY || op == OP_LDTMP) |=> ($stable(acc_o) && $stable(carry_o))); // R3
endmodule

// File: tb/tb_mac_datapath.sv
// Bench for mac_datapath: seeded random ops mixed with directed sweeps,
// each result compared with a reference computed by bench functions.
module tb_mac_datapath;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  op;
    logic        src_sel;
    logic [15:0] data;
    logic [4:0]  scale;
    logic        sxm;
    logic        sgn;
    logic [1:0]  psh;
    logic        st_hi;
    logic [2:0]  st_sh;
    logic [15:0] store;
    logic [31:0] acc, prod;
    logic [15:0] tmp;
    logic        carry;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] m_acc, m_prod;
    logic [15:0] m_tmp;
    logic        m_c;

    always #10 clk = ~clk;

    mac_datapath dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .src_sel_i(src_sel), .data_i(data),
        .scale_i(scale), .sxm_i(sxm), .signed_mul_i(sgn), .pshift_i(psh),
        .store_high_i(st_hi), .store_shift_i(st_sh), .store_o(store),
        .acc_o(acc), .prod_o(prod), .tmp_o(tmp), .carry_o(carry)
    );

    function automatic logic [31:0] f_scale(logic [15:0] d, logic [4:0] a, logic sx);
        int amt = (a > 16) ? 16 : int'(a);
        logic [31:0] w = sx ? {{16{d[15]}}, d} : {16'h0, d};
        return w << amt;
    endfunction

    function automatic logic [31:0] f_psh(logic [31:0] p, logic [1:0] m);
        case (m)
            2'd1: return p << 1;
            2'd2: return p << 4;
            2'd3: return 32'($signed(p) >>> 6);
            default: return p;
        endcase
    endfunction

    function automatic logic [31:0] f_mul(logic [15:0] a, logic [15:0] b, logic s);
        logic signed [31:0] sa = $signed({{16{a[15]}}, a});
        logic signed [31:0] sb = $signed({{16{b[15]}}, b});
        if (s) return 32'(sa * sb);
        return {16'h0, a} * {16'h0, b};
    endfunction

    function automatic string f_req(logic [3:0] o);
        case (o)
            4'd1: return "R5";
            4'd2, 4'd3: return "R6";
            4'd4, 4'd5, 4'd6: return "R7";
            4'd7, 4'd8: return "R3";
            4'd9: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string req, logic [80:0] act, logic [80:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model update for one op with the currently driven inputs.
    task automatic model_step();
        logic [31:0] operand = (src_sel || op == 4'd9) ? f_psh(m_prod, psh) : f_scale(data, scale, sxm);
        logic [32:0] t;
        case (op)
            4'd1: m_acc = operand;
            4'd2, 4'd9: begin
                t = {1'b0, m_acc} + {1'b0, operand};
                m_acc = t[31:0]; m_c = t[32];
            end
            4'd3: begin
                m_c = (m_acc >= operand);
                m_acc = m_acc - operand;
            end
            4'd4: m_acc = {16'h0, m_acc[15:0] & operand[15:0]};
            4'd5: m_acc = {16'h0, m_acc[15:0] | operand[15:0]};
            4'd6: m_acc = {16'h0, m_acc[15:0] ^ operand[15:0]};
            default: ;
        endcase
        if (op == 4'd8 || op == 4'd9) m_prod = f_mul(m_tmp, data, sgn);
        if (op == 4'd7) m_tmp = data;
    endtask

    // Drive one op at a falling edge, clock it, check at the next falling edge.
    task automatic step(string req, logic [3:0] o, logic ss, logic [15:0] d,
                        logic [4:0] sc, logic sx, logic sg, logic [1:0] ps);
        op = o; src_sel = ss; data = d; scale = sc; sxm = sx; sgn = sg; psh = ps;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(req, {acc, prod, tmp, carry}, {m_acc, m_prod, m_tmp, m_c});
    endtask

    task automatic check_store(logic hi, logic [2:0] s);
        logic [31:0] f = m_acc << s;
        logic [15:0] l = m_acc[15:0] << s;
        st_hi = hi; st_sh = s;
        #1;
        check("R9", {65'h0, store}, {65'h0, hi ? f[31:16] : l});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2741));
        rst_n = 1'b0; op = 4'd0; src_sel = 1'b0; data = 16'h0; scale = 5'd0;
        sxm = 1'b0; sgn = 1'b0; psh = 2'd0; st_hi = 1'b0; st_sh = 3'd0;
        m_acc = '0; m_prod = '0; m_tmp = '0; m_c = 1'b0;
        // Drive junk during reset; it must not reach the registers.
        repeat (3) @(negedge clk);
        op = 4'd7; data = 16'hBEEF;
        @(negedge clk);
        check("R1", {acc, prod, tmp, carry}, 81'h0);
        op = 4'd0;
        rst_n = 1'b1;

        // R2: every scale amount, both sign modes, and a saturating amount.
        for (int a = 0; a <= 17; a++) begin
            for (int s = 0; s < 2; s++) begin
                step("R2", 4'd1, 1'b0, 16'h8A5B, (a == 17) ? 5'd29 : 5'(a), s[0], 1'b0, 2'd0);
            end
        end

        // R3 / R4: load temporary, multiply, then load each product shift.
        step("R3", 4'd7, 1'b0, 16'hFF9C, 5'd0, 1'b0, 1'b0, 2'd0);
        step("R3", 4'd8, 1'b0, 16'h0123, 5'd0, 1'b0, 1'b1, 2'd0);
        for (int m = 0; m < 4; m++) step("R4", 4'd1, 1'b1, 16'h0, 5'd0, 1'b0, 1'b0, 2'(m));
        step("R3", 4'd8, 1'b0, 16'hFF9C, 5'd0, 1'b0, 1'b0, 2'd0);
        for (int m = 0; m < 4; m++) step("R4", 4'd1, 1'b1, 16'h0, 5'd0, 1'b0, 1'b0, 2'(m));

        // R6: carry out on add, borrow and no-borrow on subtract.
        step("R5", 4'd1, 1'b0, 16'hFFFF, 5'd16, 1'b1, 1'b0, 2'd0);
        step("R6", 4'd2, 1'b0, 16'h0001, 5'd16, 1'b0, 1'b0, 2'd0);
        step("R6", 4'd3, 1'b0, 16'h0001, 5'd0, 1'b0, 1'b0, 2'd0);
        step("R6", 4'd3, 1'b0, 16'h0000, 5'd0, 1'b0, 1'b0, 2'd0);

        // R7: logical ops clear the upper half.
        step("R5", 4'd1, 1'b0, 16'hF0F0, 5'd8, 1'b1, 1'b0, 2'd0);
        step("R7", 4'd5, 1'b0, 16'h0F0F, 5'd0, 1'b0, 1'b0, 2'd0);
        step("R7", 4'd4, 1'b0, 16'h3C3C, 5'd0, 1'b0, 1'b0, 2'd0);
        step("R7", 4'd6, 1'b0, 16'hFFFF, 5'd0, 1'b0, 1'b0, 2'd0);

        // R8: back-to-back multiply-accumulate with src_sel low.
        step("R3", 4'd7, 1'b0, 16'h7FFF, 5'd0, 1'b0, 1'b0, 2'd0);
        for (int k = 0; k < 4; k++) step("R8", 4'd9, 1'b0, 16'(16'h7FF0 + k), 5'd3, 1'b0, 1'b1, 2'(k));

        // R9: both halves at every store shift.
        step("R5", 4'd1, 1'b0, 16'hC3A5, 5'd9, 1'b1, 1'b0, 2'd0);
        for (int s = 0; s < 8; s++) begin
            check_store(1'b1, 3'(s));
            check_store(1'b0, 3'(s));
        end
        step("R9", 4'd0, 1'b0, 16'h0, 5'd0, 1'b0, 1'b0, 2'd0);

        // R10: unused codes change nothing.
        for (int c = 10; c < 16; c++) step("R10", 4'(c), 1'b1, 16'hABCD, 5'd4, 1'b1, 1'b1, 2'd2);

        // Random mix over every op code and input.
        for (int i = 0; i < 600; i++) begin
            logic [3:0] o = 4'($urandom % 16);
            if ($urandom % 4 != 0) o = 4'($urandom % 10);
            step(f_req(o), o, 1'($urandom), 16'($urandom), 5'($urandom), 1'($urandom),
                 1'($urandom), 2'($urandom));
            if (i % 8 == 0) check_store(1'($urandom), 3'($urandom));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule